// File: doc/BRIEF.md
# Shift-Wire Transport Operation Engine

This block keeps the classical occupancy picture of a grid of shift-register wires that carry tokens between a memory area and a set of operation slots. Tokens live in memory cells, drop onto memory lanes, ride a shared lateral bus across a fixed band of nine vertical transfer columns, enter slot lanes from the last column, and finally rise into slots. Every wire moves all of its tokens together, one position per step. No wire may push a token past either of its ends.

Each clock, the block can take one bundle of transport operations. It checks the bundle against the current occupancy. If the bundle is legal, it applies the whole bundle in one step, which stands for 0.1 µs of device time. If the bundle is illegal, it rejects the whole bundle, leaves every occupancy bit as it was, and reports the first rule that was broken. The occupancy of every region is visible at all times on output ports, so a scheduler or checker can follow the token positions.

Top module: `shift_wire_engine`

## Requirements
- R1: After reset, every memory cell holds a token (CELLS_FULL=1). The lanes, columns, slot lanes and slots are all empty, `st_valid` is 0 and `in_ready` is 1.
- R2: An accepted East moves every memory lane one place toward the column band. Lane position `r*MEM_W+m` goes to `m+1`. The token at the east end of lane r enters column 0 at grid row 2r+1. Every column position (j,g) moves to column j+1, row g.
- R3: A bundle that asks for East together with any North, South, Unload or lane-load request is rejected with code 1. Slot loads may accompany East.
- R4: North(j) moves column j up by one row (toward row 0), and South(j) moves it down by one row. Columns move independently. Column bits are indexed `j*NR+g`, with NR = 2*SLOTS. Code 2 is reported for any of these: North and South on the same column; a lane load while column 8 is moving; or a slot load on a slot lane that is being loaded in the same bundle.
- R5: Unload of cell `r*MEM_W+m` clears that cell and sets the same index in the memory lanes. Unloading an empty cell gives code 3. Unloading onto an occupied lane position gives code 5.
- R6: Lane load k takes the token at column 8, row 2k+1. It shifts slot lane k one place from position 0 (index `k*OZ_COLS`) toward position OZ_COLS-1, and puts the new token at position 0. If that source is empty, the code is 3.
- R7: Slot load `k*OZ_COLS+c` moves the token from slot-lane position c of lane k into slot c of row k. Code 3 is given if the source is empty, and code 5 if the slot is already full. Slots never empty again.
- R8: Code 4 is reported when a move would push a token past a wire end. This covers: East with any token in column 8; North with row 0 occupied; South with row NR-1 occupied; and a lane load with the far end of the slot lane occupied.
- R9: When several rules fail, the lowest code is reported. A rejected bundle leaves all occupancy unchanged. The status (`st_accept` is 1 exactly when `st_code` is 0) appears on the cycle after the bundle.
- R10: The total number of tokens across all regions never changes.
- R11: `in_ready` stays high. Every cycle with `in_valid` gives exactly one status on the next cycle. A cycle without `in_valid` changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Bundle present |
| in_ready | output | 1 | Always ready |
| op_east | input | 1 | Shift the lateral bus one place |
| op_north | input | 9 | Per-column upward shift |
| op_south | input | 9 | Per-column downward shift |
| op_unload | input | SLOTS*MEM_W | Per-cell drop onto its lane |
| op_load_row | input | SLOTS | Per slot lane, take from column 8 |
| op_load_slot | input | SLOTS*OZ_COLS | Per slot, raise from its lane |
| st_valid | output | 1 | Status present |
| st_accept | output | 1 | Bundle applied |
| st_code | output | 3 | 0 ok, 1 East mix, 2 wire conflict, 3 empty source, 4 edge, 5 collision |
| occ_cell | output | SLOTS*MEM_W | Memory cell occupancy |
| occ_mrow | output | SLOTS*MEM_W | Memory lane occupancy |
| occ_tcol | output | 9*2*SLOTS | Column occupancy |
| occ_ozrow | output | SLOTS*OZ_COLS | Slot lane occupancy |
| occ_slot | output | SLOTS*OZ_COLS | Slot occupancy |

## Verification
The in-module properties check several things on every cycle: token conservation, the frozen state after any rejection, the one-to-one timing between bundles and statuses, the agreement between the accept flag and the code, the never-emptying slots, the East-mix code, and the lane-end feed into column 0 on East. Other behaviour can only be shown by the bench's scenarios, with a behavioural model compared on every clock. These scenarios cover the exact destination of each move, the priority among simultaneous violations, and walks that carry tokens the full width of the column band and up into slots, hitting each wire end on the way.

// File: rtl/shift_wire_engine.sv
module shift_wire_engine #(
  parameter int SLOTS      = 2,
  parameter int MEM_W      = 3,
  parameter int OZ_COLS    = 2,
  parameter bit CELLS_FULL = 1'b1,
  localparam int TC = 9,
  localparam int NR = 2 * SLOTS,
  localparam int NC = SLOTS * MEM_W,
  localparam int NT = TC * NR,
  localparam int NO = SLOTS * OZ_COLS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          op_east,
  input  logic [TC-1:0] op_north,
  input  logic [TC-1:0] op_south,
  input  logic [NC-1:0] op_unload,
  input  logic [SLOTS-1:0] op_load_row,
  input  logic [NO-1:0] op_load_slot,
  output logic          st_valid,
  output logic          st_accept,
  output logic [2:0]    st_code,
  output logic [NC-1:0] occ_cell,
  output logic [NC-1:0] occ_mrow,
  output logic [NT-1:0] occ_tcol,
  output logic [NO-1:0] occ_ozrow,
  output logic [NO-1:0] occ_slot
);
  localparam int LAST = (TC - 1) * NR;

  logic [NC-1:0] cell_n, mrow_n;
  logic [NT-1:0] tcol_n;
  logic [NO-1:0] ozrow_n, slot_n;
  logic mix, clash, empty, edge_hit, hit;
  logic [2:0] code;

  assign in_ready = 1'b1;

  always_comb begin
    mix   = op_east & (|op_north | |op_south | |op_unload | |op_load_row);
    clash = |(op_north & op_south) | (|op_load_row & (op_north[TC-1] | op_south[TC-1]));
    empty = |(op_unload & ~occ_cell) | |(op_load_slot & ~occ_ozrow);
    edge_hit = op_east & |occ_tcol[LAST +: NR];
    hit   = |(op_unload & occ_mrow) | |(op_load_slot & occ_slot);
    for (int j = 0; j < TC; j++) begin
      edge_hit |= op_north[j] & occ_tcol[j*NR];
      edge_hit |= op_south[j] & occ_tcol[j*NR + NR - 1];
    end
    for (int k = 0; k < SLOTS; k++) begin
      clash    |= op_load_row[k] & |op_load_slot[k*OZ_COLS +: OZ_COLS];
      empty    |= op_load_row[k] & ~occ_tcol[LAST + 2*k + 1];
      edge_hit |= op_load_row[k] & occ_ozrow[k*OZ_COLS + OZ_COLS - 1];
    end
    code = mix ? 3'd1 : clash ? 3'd2 : empty ? 3'd3 : edge_hit ? 3'd4 : hit ? 3'd5 : 3'd0;
  end

  always_comb begin
    cell_n = occ_cell & ~op_unload;
    slot_n = occ_slot | op_load_slot;
    mrow_n = occ_mrow | op_unload;
    tcol_n = occ_tcol;
    if (op_east) begin
      for (int r = 0; r < SLOTS; r++)
        for (int m = 0; m < MEM_W; m++)
          mrow_n[r*MEM_W+m] = (m == 0) ? 1'b0 : occ_mrow[r*MEM_W+m-1];
      for (int j = 0; j < TC; j++)
        for (int g = 0; g < NR; g++)
          if (j == 0) tcol_n[g] = (g % 2 == 1) ? occ_mrow[(g/2)*MEM_W + MEM_W - 1] : 1'b0;
          else        tcol_n[j*NR+g] = occ_tcol[(j-1)*NR+g];
    end else begin
      for (int j = 0; j < TC; j++)
        for (int g = 0; g < NR; g++)
          if (op_north[j])      tcol_n[j*NR+g] = (g == NR-1) ? 1'b0 : occ_tcol[j*NR+g+1];
          else if (op_south[j]) tcol_n[j*NR+g] = (g == 0) ? 1'b0 : occ_tcol[j*NR+g-1];
      for (int k = 0; k < SLOTS; k++)
        if (op_load_row[k]) tcol_n[LAST + 2*k + 1] = 1'b0;
    end
    ozrow_n = occ_ozrow;
    for (int k = 0; k < SLOTS; k++)
      if (op_load_row[k])
        for (int c = 0; c < OZ_COLS; c++)
          ozrow_n[k*OZ_COLS+c] = (c == 0) ? 1'b1 : occ_ozrow[k*OZ_COLS+c-1];
    ozrow_n &= ~op_load_slot;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_cell  <= {NC{CELLS_FULL}};
      occ_mrow  <= '0;
      occ_tcol  <= '0;
      occ_ozrow <= '0;
      occ_slot  <= '0;
      st_valid  <= 1'b0;
      st_accept <= 1'b0;
      st_code   <= 3'd0;
    end else begin
      st_valid <= in_valid;
      if (in_valid) begin
        st_accept <= (code == 3'd0);
        st_code   <= code;
      end
      if (in_valid && code == 3'd0) begin
        occ_cell  <= cell_n;
        occ_mrow  <= mrow_n;
        occ_tcol  <= tcol_n;
        occ_ozrow <= ozrow_n;
        occ_slot  <= slot_n;
      end
    end
  end

  p_conserve_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones({occ_cell, occ_mrow, occ_tcol, occ_ozrow, occ_slot})
         == $past($countones({occ_cell, occ_mrow, occ_tcol, occ_ozrow, occ_slot})));

  p_reject_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && code != 3'd0) |=> $stable({occ_cell, occ_mrow, occ_tcol, occ_ozrow, occ_slot}));

  p_status_pair_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> st_valid);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!st_valid && $stable({occ_cell, occ_mrow, occ_tcol, occ_ozrow, occ_slot})));

  p_accept_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> (st_accept == (st_code == 3'd0)));

  p_east_mix_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_east && (|op_north || |op_unload)) |=> (st_code == 3'd1));

  p_east_feed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_east && code == 3'd0) |=> (occ_tcol[1] == $past(occ_mrow[MEM_W-1])));

  p_slot_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(occ_slot) & ~occ_slot) == '0));
endmodule

// File: tb/tb_shift_wire_engine.sv
module tb_shift_wire_engine;
  localparam int S = 2, MW = 3, OC = 2, TC = 9, NR = 4;
  localparam int NC = S*MW, NT = TC*NR, NO = S*OC;

  logic clk = 0, rst_n = 0, in_valid = 0, op_east = 0;
  logic [TC-1:0] op_north = 0, op_south = 0;
  logic [NC-1:0] op_unload = 0;
  logic [S-1:0] op_load_row = 0;
  logic [NO-1:0] op_load_slot = 0;
  logic in_ready, st_valid, st_accept;
  logic [2:0] st_code;
  logic [NC-1:0] occ_cell, occ_mrow;
  logic [NT-1:0] occ_tcol;
  logic [NO-1:0] occ_ozrow, occ_slot;

  logic [NC-1:0] m_cell, m_mrow;
  logic [NT-1:0] m_tcol;
  logic [NO-1:0] m_oz, m_sl;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  shift_wire_engine #(.SLOTS(S), .MEM_W(MW), .OZ_COLS(OC)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_east(op_east), .op_north(op_north), .op_south(op_south),
    .op_unload(op_unload), .op_load_row(op_load_row), .op_load_slot(op_load_slot),
    .st_valid(st_valid), .st_accept(st_accept), .st_code(st_code),
    .occ_cell(occ_cell), .occ_mrow(occ_mrow), .occ_tcol(occ_tcol),
    .occ_ozrow(occ_ozrow), .occ_slot(occ_slot));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int rule(bit e, logic [TC-1:0] n, logic [TC-1:0] s, logic [NC-1:0] u,
                              logic [S-1:0] lr, logic [NO-1:0] ls);
    bit mx, cl, em, ed, co;
    mx = e && (n != 0 || s != 0 || u != 0 || lr != 0);
    cl = ((n & s) != 0) || (lr != 0 && (n[TC-1] || s[TC-1]));
    em = ((u & ~m_cell) != 0) || ((ls & ~m_oz) != 0);
    ed = e && (m_tcol[NT-1 -: NR] != 0);
    co = ((u & m_mrow) != 0) || ((ls & m_sl) != 0);
    for (int j = 0; j < TC; j++) begin
      if (n[j] && m_tcol[j*NR]) ed = 1;
      if (s[j] && m_tcol[j*NR+NR-1]) ed = 1;
    end
    for (int k = 0; k < S; k++) if (lr[k]) begin
      if (ls[k*OC +: OC] != 0) cl = 1;
      if (!m_tcol[(TC-1)*NR + 2*k + 1]) em = 1;
      if (m_oz[k*OC + OC - 1]) ed = 1;
    end
    if (mx) return 1;
    if (cl) return 2;
    if (em) return 3;
    if (ed) return 4;
    if (co) return 5;
    return 0;
  endfunction

  task automatic apply(bit e, logic [TC-1:0] n, logic [TC-1:0] s, logic [NC-1:0] u,
                       logic [S-1:0] lr, logic [NO-1:0] ls);
    logic [NC-1:0] nm;
    logic [NT-1:0] nt;
    logic [NO-1:0] no;
    nm = m_mrow | u;
    nt = m_tcol;
    no = m_oz;
    if (e) begin
      for (int r = 0; r < S; r++) for (int m = MW-1; m >= 0; m--)
        nm[r*MW+m] = (m > 0) ? m_mrow[r*MW+m-1] : 1'b0;
      for (int j = TC-1; j >= 0; j--) for (int g = 0; g < NR; g++)
        nt[j*NR+g] = (j > 0) ? m_tcol[(j-1)*NR+g] : ((g % 2 == 1) ? m_mrow[(g/2)*MW+MW-1] : 1'b0);
    end else begin
      for (int j = 0; j < TC; j++) for (int g = 0; g < NR; g++) begin
        if (n[j]) nt[j*NR+g] = (g < NR-1) ? m_tcol[j*NR+g+1] : 1'b0;
        if (s[j]) nt[j*NR+g] = (g > 0) ? m_tcol[j*NR+g-1] : 1'b0;
      end
      for (int k = 0; k < S; k++) if (lr[k]) nt[(TC-1)*NR+2*k+1] = 1'b0;
    end
    for (int k = 0; k < S; k++) if (lr[k])
      for (int c = OC-1; c >= 0; c--) no[k*OC+c] = (c > 0) ? m_oz[k*OC+c-1] : 1'b1;
    m_cell = m_cell & ~u;
    m_mrow = nm;
    m_tcol = nt;
    m_oz = no & ~ls;
    m_sl = m_sl | ls;
  endtask

  task automatic compare(input string tag, input bit sv, input bit acc, input int cd);
    check(st_valid == sv, {tag, " R11 status valid"}, st_valid, sv);
    if (sv) begin
      check(st_code == cd, {tag, " R9 code"}, st_code, cd);
      check(st_accept == (cd == 0), {tag, " R9 accept"}, st_accept, acc);
    end
    check(occ_cell == m_cell, {tag, " R5 cells"}, occ_cell, m_cell);
    check(occ_mrow == m_mrow, {tag, " R2 lanes"}, occ_mrow, m_mrow);
    check(occ_tcol == m_tcol, {tag, " R4 columns"}, occ_tcol, m_tcol);
    check(occ_ozrow == m_oz, {tag, " R6 slot lanes"}, occ_ozrow, m_oz);
    check(occ_slot == m_sl, {tag, " R7 slots"}, occ_slot, m_sl);
    check($countones({occ_cell, occ_mrow, occ_tcol, occ_ozrow, occ_slot}) == NC, "R10 token count",
          $countones({occ_cell, occ_mrow, occ_tcol, occ_ozrow, occ_slot}), NC);
  endtask

  task automatic step(bit e, logic [TC-1:0] n, logic [TC-1:0] s, logic [NC-1:0] u,
                      logic [S-1:0] lr, logic [NO-1:0] ls, int want, string tag);
    int cd;
    op_east = e; op_north = n; op_south = s; op_unload = u;
    op_load_row = lr; op_load_slot = ls; in_valid = 1;
    cd = rule(e, n, s, u, lr, ls);
    if (want >= 0) check(cd == want, {tag, " scenario intent"}, cd, want);
    if (cd == 0) apply(e, n, s, u, lr, ls);
    @(negedge clk);
    in_valid = 0;
    compare(tag, 1'b1, cd == 0, cd);
    if (want >= 0) check(st_code == want, {tag, " directed code"}, st_code, want);
  endtask

  task automatic idle(string tag);
    in_valid = 0;
    @(negedge clk);
    compare(tag, 1'b0, 1'b0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    m_cell = '1; m_mrow = '0; m_tcol = '0; m_oz = '0; m_sl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check(in_ready == 1'b1, "R1 ready", in_ready, 1);
    compare("R1 reset", 1'b0, 1'b0, 0);
    step(0, 0, 0, 6'b100100, 0, 0, 0, "R5 unload pair");
    repeat (9) step(1, 0, 0, 0, 0, 0, 0, "R2 east walk");
    step(1, 0, 0, 0, 0, 0, 4, "R8 east at column end");
    step(1, 9'h001, 0, 0, 0, 0, 1, "R3 east with north");
    step(0, 9'h100, 9'h100, 0, 0, 0, 2, "R4 north and south same column");
    step(0, 0, 9'h100, 0, 2'b01, 0, 2, "R4 lane load with column 8 moving");
    step(0, 0, 0, 0, 2'b11, 0, 0, "R6 lane loads");
    step(0, 0, 0, 0, 2'b01, 0, 3, "R6 lane load empty source");
    step(0, 0, 0, 0, 0, 4'b0101, 0, "R7 slot loads");
    step(0, 0, 0, 0, 0, 4'b0001, 3, "R7 slot load empty source");
    step(0, 0, 0, 6'b000100, 0, 0, 3, "R5 unload empty cell");
    step(0, 0, 0, 6'b000010, 0, 0, 0, "R5 unload");
    repeat (10) step(1, 0, 0, 0, 0, 0, 0, "R2 east walk two");
    step(0, 9'h100, 0, 0, 0, 0, 0, "R4 north");
    step(0, 9'h100, 0, 0, 0, 0, 4, "R8 north at top");
    step(0, 0, 9'h100, 0, 0, 0, 0, "R4 south");
    step(0, 0, 0, 0, 2'b01, 4'b0001, 2, "R4 slot load on loading lane");
    step(0, 0, 0, 0, 2'b01, 0, 0, "R6 lane load");
    step(0, 0, 0, 6'b000001, 0, 0, 0, "R5 unload three");
    repeat (11) step(1, 0, 0, 0, 0, 0, 0, "R2 east walk three");
    step(0, 0, 0, 0, 2'b01, 0, 0, "R6 lane shift");
    step(0, 0, 0, 0, 0, 4'b0001, 5, "R7 slot collision");
    step(0, 0, 0, 6'b001000, 0, 0, 0, "R5 unload lane one");
    step(1, 0, 0, 0, 0, 0, 0, "R2 east one");
    step(0, 0, 0, 6'b010000, 0, 0, 5, "R5 unload collision");
    idle("R11 idle");
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 3) == 0, TC'($urandom & $urandom & $urandom), TC'($urandom & $urandom & $urandom),
           NC'($urandom & $urandom & $urandom), S'($urandom & $urandom), NO'($urandom & $urandom),
           -1, "R9 random");
      if (i % 7 == 0) idle("R11 random idle");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule